// File: doc/BRIEF.md
# Epoch Signature Race Checker

This block takes completed execution-block records from the threads of a multithreaded system and flags pairs of records that may have touched the same memory location without synchronization. Each record carries the issuing thread id, a vector-clock timestamp, a read-address signature and a write-address signature. The checker keeps a short history of recent records for each thread. Every new record is compared with the stored records of all other threads.

Two records are reported when their timestamps are concurrent, meaning neither one happened before the other. They must also have a signature overlap that involves at least one write. Overlap is the bitwise AND of signatures, so it can give false positives but never false negatives. A flag therefore marks a possible race, and a replay step is needed to confirm it.

Records enter with a valid/ready handshake. The checker examines one stored record per clock cycle. It holds ready low until its whole history has been scanned, and then it files the new record in its thread's history.

Top module: `epoch_race_checker`

## Requirements
- R1: After reset, `in_ready` is 1, `race_valid` is 0 and every history is empty, so the first record never raises a flag.
- R2: A record is accepted on a clock edge where `in_valid` and `in_ready` are both 1. After that edge, `in_ready` stays 0 for exactly THREADS*DEPTH cycles and then returns to 1.
- R3: A stored record is flagged only if its timestamp is concurrent with the new one. Element t of the timestamp sits at `in_ts[t*TS_W +: TS_W]`. Vector A is ordered before or equal to vector B when every element of A is less than or equal to the matching element of B. If either vector is ordered before or equal to the other, including the case where they are identical, there is no flag.
- R4: When the new write signature and the stored write signature share a set bit and the timestamps are concurrent, a flag is raised.
- R5: A flag is also raised for new-write against stored-read and for new-read against stored-write. Overlap between two read signatures alone never raises a flag.
- R6: A record is never compared with records from its own thread.
- R7: Each thread keeps only its DEPTH most recent records. When a thread already holds DEPTH records, pushing a new one drops its oldest, and the dropped record can no longer cause a flag.
- R8: Each flagged pair gives a one-cycle `race_valid` pulse. `race_tid_new` is the id of the incoming record's thread and `race_tid_old` is the id of the stored record's thread, and the two are never equal. Pulses for one record appear in ascending stored-thread order and, within a thread, from newest to oldest record.
- R9: Signatures with no common set bit never raise a flag, whatever the timestamps are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming record is present |
| in_ready | output | 1 | Checker can accept a record |
| in_tid | input | TID_W | Thread id of the record |
| in_ts | input | THREADS*TS_W | Vector-clock timestamp, element t at bits t*TS_W |
| in_rsig | input | SIG_W | Read-address signature |
| in_wsig | input | SIG_W | Write-address signature |
| race_valid | output | 1 | One-cycle possible-race event |
| race_tid_new | output | TID_W | Thread id of the incoming record |
| race_tid_old | output | TID_W | Thread id of the stored record |

## Verification
The bench builds the block with its defaults: four threads, a history depth of four, 8-bit clock elements and 32-bit signatures. With four threads, one record can be checked against up to three foreign histories in a single scan. A depth of four lets a short directed run fill a history and then push a fifth record, which shows the oldest record leaving the comparison window. In the random phase, signatures use only the low eight bits and clock elements stay small. This makes overlapping, disjoint, ordered and concurrent pairs all occur often.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/erc_history.sv
module erc_history #(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 80,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic               rd_valid,
  output logic [ENTRY_W-1:0] rd_data
);
  // slot 0 holds the newest record, slot DEPTH-1 the oldest
  logic [ENTRY_W-1:0] data_q [DEPTH];
  logic [ENTRY_W-1:0] data_d [DEPTH];
  logic [DEPTH-1:0]   vld_q;
  logic [DEPTH-1:0]   vld_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
        always_comb begin
          data_d[i] = push_data;
          vld_d[i]  = 1'b1;
        end
      end else begin : g_body
        always_comb begin
          data_d[i] = data_q[i-1];
          vld_d[i]  = vld_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        if (push_en) begin
          data_q[i] <= data_d[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (push_en) begin
      vld_q <= vld_d;
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_data  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_slot == SLOT_W'(i)) begin
        rd_valid = vld_q[i];
        rd_data  = data_q[i];
      end
    end
  end
endmodule

// File: rtl/erc_compare.sv
module erc_compare #(
  parameter int THREADS = 4,
  parameter int TS_W    = 8,
  parameter int SIG_W   = 32,
  localparam int TSV_W  = THREADS * TS_W
) (
  input  logic [TSV_W-1:0] new_ts,
  input  logic [SIG_W-1:0] new_rsig,
  input  logic [SIG_W-1:0] new_wsig,
  input  logic [TSV_W-1:0] old_ts,
  input  logic [SIG_W-1:0] old_rsig,
  input  logic [SIG_W-1:0] old_wsig,
  output logic             concurrent,
  output logic             conflict
);
  logic [THREADS-1:0] new_le_old;
  logic [THREADS-1:0] old_le_new;

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_elem
      assign new_le_old[t] = new_ts[t*TS_W +: TS_W] <= old_ts[t*TS_W +: TS_W];
      assign old_le_new[t] = old_ts[t*TS_W +: TS_W] <= new_ts[t*TS_W +: TS_W];
    end
  endgenerate

  logic [SIG_W-1:0] overlap;

  always_comb begin
    concurrent = !(&new_le_old) && !(&old_le_new);
    overlap    = (new_wsig & old_wsig) | (new_wsig & old_rsig) | (new_rsig & old_wsig);
    conflict   = |overlap;
  end
endmodule

// File: rtl/erc_scan_ctrl.sv
module erc_scan_ctrl
  import erc_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int TID_W   = 2,
  parameter int SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              capture,
  output logic              scan_active,
  output logic [TID_W-1:0]  scan_thr,
  output logic [SLOT_W-1:0] scan_slot,
  output logic              scan_last
);
  scan_state_e       state_q, state_d;
  logic [TID_W-1:0]  thr_q, thr_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              step_en;

  always_comb begin
    in_ready    = (state_q == ST_IDLE);
    capture     = in_ready && in_valid;
    scan_active = (state_q == ST_SCAN);
    scan_last   = scan_active && (thr_q == TID_W'(THREADS-1)) && (slot_q == SLOT_W'(DEPTH-1));
    scan_thr    = thr_q;
    scan_slot   = slot_q;
  end

  always_comb begin
    state_d = state_q;
    thr_d   = thr_q;
    slot_d  = slot_q;
    step_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_SCAN;
          thr_d   = '0;
          slot_d  = '0;
          step_en = 1'b1;
        end
      end
      ST_SCAN: begin
        step_en = 1'b1;
        if (scan_last) begin
          state_d = ST_IDLE;
        end else if (slot_q == SLOT_W'(DEPTH-1)) begin
          slot_d = '0;
          thr_d  = thr_q + TID_W'(1);
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      thr_q   <= '0;
      slot_q  <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      thr_q   <= thr_d;
      slot_q  <= slot_d;
    end
  end
endmodule

// File: rtl/epoch_race_checker.sv
module epoch_race_checker #(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int TS_W    = 8,
  parameter int SIG_W   = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int TSV_W  = THREADS * TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TID_W-1:0] in_tid,
  input  logic [TSV_W-1:0] in_ts,
  input  logic [SIG_W-1:0] in_rsig,
  input  logic [SIG_W-1:0] in_wsig,
  output logic             race_valid,
  output logic [TID_W-1:0] race_tid_new,
  output logic [TID_W-1:0] race_tid_old
);
  localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENTRY_W = TSV_W + 2 * SIG_W;

  logic              capture;
  logic              scan_active;
  logic              scan_last;
  logic [TID_W-1:0]  scan_thr;
  logic [SLOT_W-1:0] scan_slot;

  erc_scan_ctrl #(
    .THREADS(THREADS),
    .DEPTH  (DEPTH),
    .TID_W  (TID_W),
    .SLOT_W (SLOT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .capture    (capture),
    .scan_active(scan_active),
    .scan_thr   (scan_thr),
    .scan_slot  (scan_slot),
    .scan_last  (scan_last)
  );

  // record under test, held for the whole scan
  logic [TID_W-1:0] cur_tid_q;
  logic [TSV_W-1:0] cur_ts_q;
  logic [SIG_W-1:0] cur_rsig_q;
  logic [SIG_W-1:0] cur_wsig_q;

  always_ff @(posedge clk) begin
    if (capture) begin
      cur_tid_q  <= in_tid;
      cur_ts_q   <= in_ts;
      cur_rsig_q <= in_rsig;
      cur_wsig_q <= in_wsig;
    end
  end

  logic [ENTRY_W-1:0] push_entry;
  logic [THREADS-1:0] hist_vld;
  logic [ENTRY_W-1:0] hist_data [THREADS];

  assign push_entry = {cur_ts_q, cur_rsig_q, cur_wsig_q};

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic push_here;
      assign push_here = scan_last && (cur_tid_q == TID_W'(t));

      erc_history #(
        .DEPTH  (DEPTH),
        .ENTRY_W(ENTRY_W),
        .SLOT_W (SLOT_W)
      ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_here),
        .push_data(push_entry),
        .rd_slot  (scan_slot),
        .rd_valid (hist_vld[t]),
        .rd_data  (hist_data[t])
      );
    end
  endgenerate

  logic               sel_vld;
  logic [ENTRY_W-1:0] sel_data;
  logic [TSV_W-1:0]   old_ts;
  logic [SIG_W-1:0]   old_rsig;
  logic [SIG_W-1:0]   old_wsig;

  always_comb begin
    sel_vld  = 1'b0;
    sel_data = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (scan_thr == TID_W'(t)) begin
        sel_vld  = hist_vld[t];
        sel_data = hist_data[t];
      end
    end
    {old_ts, old_rsig, old_wsig} = sel_data;
  end

  logic pair_concurrent;
  logic pair_conflict;

  erc_compare #(
    .THREADS(THREADS),
    .TS_W   (TS_W),
    .SIG_W  (SIG_W)
  ) u_cmp (
    .new_ts    (cur_ts_q),
    .new_rsig  (cur_rsig_q),
    .new_wsig  (cur_wsig_q),
    .old_ts    (old_ts),
    .old_rsig  (old_rsig),
    .old_wsig  (old_wsig),
    .concurrent(pair_concurrent),
    .conflict  (pair_conflict)
  );

  logic hit;
  logic race_q;
  logic [TID_W-1:0] tid_new_q;
  logic [TID_W-1:0] tid_old_q;

  assign hit = scan_active && sel_vld && (scan_thr != cur_tid_q)
               && pair_concurrent && pair_conflict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      race_q <= 1'b0;
    end else begin
      race_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_new_q <= '0;
      tid_old_q <= '0;
    end else if (hit) begin
      tid_new_q <= cur_tid_q;
      tid_old_q <= scan_thr;
    end
  end

  assign race_valid   = race_q;
  assign race_tid_new = tid_new_q;
  assign race_tid_old = tid_old_q;
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int TID_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             race_valid,
  input logic [TID_W-1:0] race_tid_new,
  input logic [TID_W-1:0] race_tid_old
);
  localparam int SCAN_N = THREADS * DEPTH;
  localparam int CNT_W  = $clog2(SCAN_N + 1) + 1;

  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else if (in_ready) begin
      busy_cnt_q <= '0;
    end else begin
      busy_cnt_q <= busy_cnt_q + CNT_W'(1);
    end
  end

  assert_accept_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_scan_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (busy_cnt_q < CNT_W'(SCAN_N)));

  assert_scan_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && busy_cnt_q == CNT_W'(SCAN_N - 1)) |=> in_ready);

  assert_foreign_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    race_valid |-> (race_tid_new != race_tid_old));

  assert_flag_follows_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    race_valid |-> $past(!in_ready));
endmodule

bind epoch_race_checker erc_checker #(
  .THREADS(THREADS),
  .DEPTH  (DEPTH),
  .TID_W  (TID_W)
) u_erc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .race_valid  (race_valid),
  .race_tid_new(race_tid_new),
  .race_tid_old(race_tid_old)
);

// File: tb/epoch_race_checker_tb.sv
module epoch_race_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 4;
  localparam int DEPTH   = 4;
  localparam int TS_W    = 8;
  localparam int SIG_W   = 32;
  localparam int TID_W   = 2;
  localparam int TSV_W   = THREADS * TS_W;
  localparam int SCAN_N  = THREADS * DEPTH;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [TID_W-1:0] in_tid;
  logic [TSV_W-1:0] in_ts;
  logic [SIG_W-1:0] in_rsig;
  logic [SIG_W-1:0] in_wsig;
  logic             race_valid;
  logic [TID_W-1:0] race_tid_new;
  logic [TID_W-1:0] race_tid_old;

  epoch_race_checker #(
    .THREADS(THREADS), .DEPTH(DEPTH), .TS_W(TS_W), .SIG_W(SIG_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tid(in_tid), .in_ts(in_ts), .in_rsig(in_rsig), .in_wsig(in_wsig),
    .race_valid(race_valid), .race_tid_new(race_tid_new), .race_tid_old(race_tid_old)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference history: index 0 newest
  logic [TSV_W-1:0] m_ts   [THREADS][DEPTH];
  logic [SIG_W-1:0] m_rsig [THREADS][DEPTH];
  logic [SIG_W-1:0] m_wsig [THREADS][DEPTH];
  bit               m_vld  [THREADS][DEPTH];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit ts_le(logic [TSV_W-1:0] a, logic [TSV_W-1:0] b);
    for (int t = 0; t < THREADS; t++)
      if (a[t*TS_W +: TS_W] > b[t*TS_W +: TS_W]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ts_conc(logic [TSV_W-1:0] a, logic [TSV_W-1:0] b);
    return !ts_le(a, b) && !ts_le(b, a);
  endfunction

  function automatic logic [TSV_W-1:0] mk_ts(int e0, int e1, int e2, int e3);
    logic [TSV_W-1:0] v;
    v[0*TS_W +: TS_W] = TS_W'(e0);
    v[1*TS_W +: TS_W] = TS_W'(e1);
    v[2*TS_W +: TS_W] = TS_W'(e2);
    v[3*TS_W +: TS_W] = TS_W'(e3);
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_tid   = '0;
    in_ts    = '0;
    in_rsig  = '0;
    in_wsig  = '0;
    rst_n    = 1'b0;
    for (int t = 0; t < THREADS; t++)
      for (int s = 0; s < DEPTH; s++) m_vld[t][s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(race_valid === 1'b0, "R1", "race_valid after reset", int'(race_valid), 0);
  endtask

  // send one record, compare flag sequence and stall length with the model
  task automatic send(int tid, logic [TSV_W-1:0] ts, logic [SIG_W-1:0] rs,
                      logic [SIG_W-1:0] ws, string req);
    int exp_q[$];
    int obs_q[$];
    int cyc;
    bit tid_ok;
    for (int t = 0; t < THREADS; t++)
      for (int s = 0; s < DEPTH; s++)
        if (m_vld[t][s] && t != tid && ts_conc(ts, m_ts[t][s]) &&
            (|((ws & m_wsig[t][s]) | (ws & m_rsig[t][s]) | (rs & m_wsig[t][s]))))
          exp_q.push_back(t);
    while (in_ready !== 1'b1) @(negedge clk);
    in_valid = 1'b1;
    in_tid   = TID_W'(tid);
    in_ts    = ts;
    in_rsig  = rs;
    in_wsig  = ws;
    @(negedge clk);
    in_valid = 1'b0;
    cyc    = 0;
    tid_ok = 1'b1;
    forever begin
      if (race_valid === 1'b1) begin
        obs_q.push_back(int'(race_tid_old));
        if (race_tid_new !== TID_W'(tid)) tid_ok = 1'b0;
      end
      if (in_ready === 1'b1) break;
      cyc++;
      if (cyc > 4 * SCAN_N) break;
      @(negedge clk);
    end
    check(cyc == SCAN_N, "R2", "stall cycles", cyc, SCAN_N);
    check(obs_q.size() == exp_q.size(), req, "flag count", obs_q.size(), exp_q.size());
    if (obs_q.size() == exp_q.size())
      foreach (exp_q[i])
        check(obs_q[i] == exp_q[i], "R8", "stored thread order", obs_q[i], exp_q[i]);
    check(tid_ok, "R8", "race_tid_new", int'(tid_ok), 1);
    for (int s = DEPTH - 1; s > 0; s--) begin
      m_ts[tid][s]   = m_ts[tid][s-1];
      m_rsig[tid][s] = m_rsig[tid][s-1];
      m_wsig[tid][s] = m_wsig[tid][s-1];
      m_vld[tid][s]  = m_vld[tid][s-1];
    end
    m_ts[tid][0]   = ts;
    m_rsig[tid][0] = rs;
    m_wsig[tid][0] = ws;
    m_vld[tid][0]  = 1'b1;
  endtask

  int clk_own [THREADS];

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R1: first record sees empty history
    send(0, mk_ts(1,0,0,0), 32'h0, 32'h1, "R1");
    // R4: concurrent write-write
    send(1, mk_ts(0,1,0,0), 32'h0, 32'h1, "R4");
    // R5 read-new vs write-old, R6 own-thread writes ignored
    send(1, mk_ts(0,2,0,0), 32'h1, 32'h0, "R6");
    // R3: ordered after thread 0, concurrent with thread 1
    send(2, mk_ts(2,0,1,0), 32'h0, 32'h1, "R3");
    // R5: read overlaps reads and writes
    send(3, mk_ts(0,0,0,1), 32'h1, 32'h0, "R5");
    // R9: disjoint signature
    send(3, mk_ts(0,0,0,2), 32'h0, 32'h100, "R9");
    // R3: identical timestamp never concurrent
    send(0, mk_ts(0,0,0,2), 32'h0, 32'h100, "R3");

    // R7: history depth, oldest dropped
    do_reset();
    send(0, mk_ts(1,0,0,0), 32'h0, 32'h4, "R7");
    for (int k = 2; k <= DEPTH; k++) send(0, mk_ts(k,0,0,0), 32'h0, 32'h0, "R7");
    send(2, mk_ts(0,0,1,0), 32'h0, 32'h4, "R7");
    send(0, mk_ts(DEPTH+1,0,0,0), 32'h0, 32'h0, "R7");
    send(3, mk_ts(0,0,0,1), 32'h0, 32'h4, "R7");

    // random mix
    do_reset();
    for (int t = 0; t < THREADS; t++) clk_own[t] = 0;
    for (int n = 0; n < 160; n++) begin
      int tid;
      logic [TSV_W-1:0] ts;
      logic [SIG_W-1:0] rs, ws;
      tid = int'($urandom_range(THREADS-1, 0));
      clk_own[tid]++;
      for (int t = 0; t < THREADS; t++)
        ts[t*TS_W +: TS_W] = (t == tid) ? TS_W'(clk_own[tid]) : TS_W'($urandom_range(4, 0));
      rs = SIG_W'(1) << $urandom_range(7, 0);
      ws = ($urandom_range(9, 0) < 3) ? '0 : (SIG_W'(1) << $urandom_range(7, 0));
      send(tid, ts, rs, ws, "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule